// File: doc/BRIEF.md
# Floating-Point Error Interrupt Bridge

This block connects a processor's active-low floating-point error output to one request line of an interrupt controller. It also drives the processor's active-low input that tells it to ignore a pending numeric error. A falling edge on the error signal sets a request latch. The latch output raises the interrupt line. When the exception handler writes to a fixed I/O port, the write clears the request and arms the ignore output. The handler can then run non-control floating-point instructions for diagnosis. The ignore output is released only when the error signal goes inactive again.

The ignore output is armed by the port write and released by the error line, so the handler may do its two clearing steps in either order. It may acknowledge the port first and clear the exception afterwards, or the reverse. In both cases the ignore output is never left active outside the handler. The error input is asynchronous and is synchronised before any use. The I/O bus is synchronous to the block clock.

Top module: `fpe_irq_bridge`

## Requirements
- R1: After synchronous reset, `fp_irq` is 0 and `fp_ign_n` is 1.
- R2: A high-to-low change on `fp_err_n` sets `fp_irq` on the third rising clock edge after the change: two synchroniser flops, then the request latch.
- R3: A cycle with `io_wr`=1 and `io_addr` exactly equal to 16'h00F0 clears `fp_irq` on the next rising edge. A write to any other address leaves both outputs unchanged.
- R4: While `fp_err_n` stays low after the request has been cleared, `fp_irq` stays 0. The latch responds only to edges, not to the low level.
- R5: A port write made while the synchronised error is low drives `fp_ign_n` to 0 on the next rising edge.
- R6: A port write made while the synchronised error is high leaves `fp_ign_n` at 1.
- R7: When `fp_err_n` returns high, `fp_ign_n` goes to 1 on the third rising edge after the change. It stays 1 for as long as the error is high.
- R8: If the error returns high before the port write, that write still clears `fp_irq` and `fp_ign_n` remains 1.
- R9: A new high-to-low change on `fp_err_n` after the ignore output was released sets `fp_irq` again.
- R10: If a detected error edge and a port write fall in the same cycle, the set wins and `fp_irq` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_err_n | input | 1 | Asynchronous active-low floating-point error from the processor |
| io_addr | input | 16 | I/O write address |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| fp_irq | output | 1 | Active-high interrupt request toward the interrupt controller |
| fp_ign_n | output | 1 | Active-low ignore-numeric-error output toward the processor |

## Verification
The main function is exercised in four patterns:
- **Port write first, then error release.** This is the normal handler order. It shows that the ignore output arms on the write and drops only when the error clears.
- **Error release first, then port write.** This is the reversed order. It shows that the ignore output never arms when the error is already gone.
- **Port write with no error pending.** This shows that the ignore output does not depend on the write alone.
- **Port write landing in the same cycle as a fresh error edge.** This tells set priority apart from clear priority.

Writes to neighbouring addresses separate an exact 16-bit decode from a partial one. A long low level after acknowledgement separates edge-triggered setting from level-triggered setting.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    localparam int unsigned IO_ADDR_W      = 16;
    localparam int unsigned ACK_PORT       = 16'h00F0;
    localparam int unsigned ERR_SYNC_DEPTH = 2;

    typedef struct packed {
        logic [IO_ADDR_W-1:0] addr;
        logic                 wr;
    } io_cmd_t;

    typedef enum logic {
        IGN_OFF   = 1'b0,
        IGN_ARMED = 1'b1
    } ign_state_e;

    typedef enum logic {
        REQ_IDLE    = 1'b0,
        REQ_PENDING = 1'b1
    } req_state_e;

    function automatic logic cmd_hits(input io_cmd_t cmd, input logic [IO_ADDR_W-1:0] port);
        return cmd.wr && (cmd.addr == port);
    endfunction

endpackage

// File: rtl/fpe_sync.sv
module fpe_sync #(
    parameter int unsigned DEPTH    = 2,
    parameter logic        RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [DEPTH-1:0] chain_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= RST_VAL;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= RST_VAL;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[DEPTH-1];
endmodule

// File: rtl/fpe_port_decode.sv
module fpe_port_decode
    import fpe_pkg::*;
#(
    parameter int unsigned          ADDR_W = IO_ADDR_W,
    parameter logic [ADDR_W-1:0]    PORT   = ADDR_W'(ACK_PORT)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              hit
);
    io_cmd_t cmd;

    always_comb begin
        cmd      = '0;
        cmd.addr = IO_ADDR_W'(addr);
        cmd.wr   = wr;
        hit      = cmd_hits(cmd, IO_ADDR_W'(PORT));
    end
endmodule

// File: rtl/fpe_req_latch.sv
module fpe_req_latch
    import fpe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic err_sync_n,
    input  logic ack_hit,
    output logic err_fall,
    output logic irq
);
    logic       err_prev_n;
    req_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) err_prev_n <= 1'b1;
        else     err_prev_n <= err_sync_n;
    end

    assign err_fall = err_prev_n & ~err_sync_n;

    always_comb begin
        state_d = state_q;
        if (err_fall)     state_d = REQ_PENDING;
        else if (ack_hit) state_d = REQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= REQ_IDLE;
        else     state_q <= state_d;
    end

    assign irq = (state_q == REQ_PENDING);
endmodule

// File: rtl/fpe_ignore_ctl.sv
module fpe_ignore_ctl
    import fpe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic err_sync_n,
    input  logic ack_hit,
    output logic ign_n
);
    ign_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (err_sync_n)   state_d = IGN_OFF;
        else if (ack_hit) state_d = IGN_ARMED;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= IGN_OFF;
        else     state_q <= state_d;
    end

    assign ign_n = (state_q != IGN_ARMED);
endmodule

// File: rtl/fpe_irq_bridge.sv
module fpe_irq_bridge
    import fpe_pkg::*;
#(
    parameter int unsigned       ADDR_W     = IO_ADDR_W,
    parameter logic [ADDR_W-1:0] PORT       = ADDR_W'(ACK_PORT),
    parameter int unsigned       SYNC_DEPTH = ERR_SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fp_err_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    output logic              fp_irq,
    output logic              fp_ign_n
);
    logic err_sync_n;
    logic ack_hit;
    logic err_fall;

    fpe_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (fp_err_n),
        .q_sync  (err_sync_n)
    );

    fpe_port_decode #(.ADDR_W(ADDR_W), .PORT(PORT)) u_dec (
        .addr (io_addr),
        .wr   (io_wr),
        .hit  (ack_hit)
    );

    fpe_req_latch u_req (
        .clk        (clk),
        .rst        (rst),
        .err_sync_n (err_sync_n),
        .ack_hit    (ack_hit),
        .err_fall   (err_fall),
        .irq        (fp_irq)
    );

    fpe_ignore_ctl u_ign (
        .clk        (clk),
        .rst        (rst),
        .err_sync_n (err_sync_n),
        .ack_hit    (ack_hit),
        .ign_n      (fp_ign_n)
    );
endmodule

// File: rtl/fpe_irq_bridge_chk.sv
module fpe_irq_bridge_chk (
    input logic clk,
    input logic rst,
    input logic err_sync_n,
    input logic err_fall,
    input logic ack_hit,
    input logic fp_irq,
    input logic fp_ign_n
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk) rst |=> (!fp_irq && fp_ign_n));

    // R2, R10: a detected edge always leaves the request pending
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
        err_fall |=> fp_irq);

    // R3
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !err_fall) |=> !fp_irq);

    // R4, R9: request only rises after a detected edge
    a_r4_rise_needs_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(fp_irq) |-> $past(err_fall));

    // R5
    a_r5_ack_arms: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !err_sync_n) |=> !fp_ign_n);

    // R6
    a_r6_arm_needs_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(fp_ign_n) |-> $past(ack_hit));

    // R7, R8
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        err_sync_n |=> fp_ign_n);
endmodule

bind fpe_irq_bridge fpe_irq_bridge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .err_sync_n (err_sync_n),
    .err_fall   (err_fall),
    .ack_hit    (ack_hit),
    .fp_irq     (fp_irq),
    .fp_ign_n   (fp_ign_n)
);

// File: tb/fpe_irq_bridge_test.sv
module fpe_irq_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fp_err_n = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        fp_irq;
    logic        fp_ign_n;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    fpe_irq_bridge uut (
        .clk      (clk),
        .rst      (rst),
        .fp_err_n (fp_err_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .fp_irq   (fp_irq),
        .fp_ign_n (fp_ign_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a);
        io_addr = a;
        io_wr   = 1'b1;
        tick(1);
        io_wr   = 1'b0;
        io_addr = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        check("R1", "irq after reset", fp_irq, 1'b0);
        check("R1", "ign_n after reset", fp_ign_n, 1'b1);
        rst = 1'b0;
        tick(2);
    endtask

    task automatic t_normal_order();
        fp_err_n = 1'b0;
        tick(2);
        check("R2", "irq before latch edge", fp_irq, 1'b0);
        tick(1);
        check("R2", "irq after third edge", fp_irq, 1'b1);
        check("R2", "ign_n while pending", fp_ign_n, 1'b1);
        io_write(16'h00F1);
        check("R3", "irq after wrong low byte", fp_irq, 1'b1);
        io_write(16'h01F0);
        check("R3", "irq after wrong high byte", fp_irq, 1'b1);
        check("R3", "ign_n after wrong address", fp_ign_n, 1'b1);
        io_write(16'h00F0);
        check("R3", "irq after port write", fp_irq, 1'b0);
        check("R5", "ign_n armed by port write", fp_ign_n, 1'b0);
        tick(6);
        check("R4", "irq while error held low", fp_irq, 1'b0);
        check("R5", "ign_n held while error low", fp_ign_n, 1'b0);
        fp_err_n = 1'b1;
        tick(2);
        check("R7", "ign_n before release edge", fp_ign_n, 1'b0);
        tick(1);
        check("R7", "ign_n released", fp_ign_n, 1'b1);
        tick(4);
        check("R7", "ign_n stays released", fp_ign_n, 1'b1);
        fp_err_n = 1'b0;
        tick(3);
        check("R9", "irq on second exception", fp_irq, 1'b1);
        io_write(16'h00F0);
        fp_err_n = 1'b1;
        tick(4);
    endtask

    task automatic t_reverse_order();
        fp_err_n = 1'b0;
        tick(3);
        check("R8", "irq pending", fp_irq, 1'b1);
        fp_err_n = 1'b1;
        tick(4);
        check("R8", "irq latched after error release", fp_irq, 1'b1);
        check("R8", "ign_n before write", fp_ign_n, 1'b1);
        io_write(16'h00F0);
        check("R8", "irq cleared late", fp_irq, 1'b0);
        check("R8", "ign_n not armed", fp_ign_n, 1'b1);
        tick(3);
        check("R8", "ign_n still inactive", fp_ign_n, 1'b1);
    endtask

    task automatic t_idle_write();
        io_write(16'h00F0);
        check("R6", "ign_n after idle write", fp_ign_n, 1'b1);
        check("R6", "irq after idle write", fp_irq, 1'b0);
    endtask

    task automatic t_collision();
        fp_err_n = 1'b0;
        tick(2);
        io_write(16'h00F0);
        check("R10", "irq when set and clear collide", fp_irq, 1'b1);
        io_write(16'h00F0);
        check("R3", "irq cleared after collision", fp_irq, 1'b0);
        fp_err_n = 1'b1;
        tick(4);
        check("R7", "ign_n after collision cleanup", fp_ign_n, 1'b1);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_normal_order();
        t_reverse_order();
        t_idle_write();
        t_collision();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule